// File: doc/BRIEF.md
# Byte-Programmed Multiply and Divide Helper

This block is a small arithmetic helper that a processor drives through byte writes on a register port. It multiplies two unsigned bytes into a 16-bit product. It also divides an unsigned 16-bit dividend by an unsigned byte, giving a 16-bit quotient and a remainder. Software writes the operands one byte at a time. The write of the final operand starts the operation. Software then polls `busy` or waits for the one-cycle `done` pulse and reads the results back as bytes.

Two result registers are visible. The quotient register is written only by a divide. The second register is shared: it holds the product after a multiply and the remainder after a divide. Both operations run serially, one bit per clock. A zero divisor skips the iteration and finishes at once with fixed results.

Top module: `arith_helper`

## Requirements
- R1: A write to address 1 sets multiplier B and starts an unsigned multiply of A (address 0) by B. After completion the shared register holds A*B and the quotient register keeps its earlier value.
- R2: A write of a non-zero value to address 4 sets the divisor and starts an unsigned divide of the dividend (low byte at address 2, high byte at address 3). After completion the quotient register holds dividend/divisor and the shared register holds dividend mod divisor, with the upper byte zero.
- R3: Writes to addresses 0, 2 and 3 store the operand and do not raise `busy` or `done`.
- R4: Writes to addresses 5, 6 and 7 have no effect on `busy`, `done` or either result register.
- R5: Writing zero to address 4 starts no iteration. On the next cycle `done` is high, `busy` is low, the quotient reads 0xFFFF and the shared register reads the dividend.
- R6: After a starting write, `busy` is high for exactly 8 cycles for a multiply and 16 cycles for a non-zero divide. `done` is high for exactly one cycle, in the first cycle after `busy` falls, and is never high together with `busy`.
- R7: The result registers change only at the end of an operation. While `busy` is high, reads return the previous results.
- R8: A starting write while `busy` is high abandons the running operation without a `done` pulse and restarts with the newly written operand. The full latency of R6 counts from the restart.
- R9: The operands are captured when the operation starts. Writes to addresses 0, 2 or 3 during `busy` do not change the running result.
- R10: After reset `busy` and `done` are low and all four result bytes read zero. Read address 0 gives the quotient low byte, 1 the quotient high byte, 2 the shared low byte and 3 the shared high byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write register select |
| wr_data | input | 8 | Write data byte |
| rd_addr | input | 2 | Result byte select |
| rd_data | output | 8 | Selected result byte, combinational |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checker evaluates several rules on every cycle. It compares the results at each `done` against a reference taken when the operation started, which covers products, quotients, remainders and the zero-divisor case. It also checks that `done` and `busy` never overlap, that the results move only on `done`, and that non-starting writes leave the unit idle. Some behaviour shows only in the bench scenarios: the exact 8- and 16-cycle latencies, the missing pulse for an abandoned operation, operand writes made during a running operation, and the byte ordering of the read port.

// File: rtl/arith_helper.sv
module arith_helper (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       done
);
  localparam logic [4:0] MUL_STEPS = 5'd8;
  localparam logic [4:0] DIV_STEPS = 5'd16;
  localparam logic [2:0] AD_OPA = 3'd0;
  localparam logic [2:0] AD_OPB = 3'd1;
  localparam logic [2:0] AD_DLO = 3'd2;
  localparam logic [2:0] AD_DHI = 3'd3;
  localparam logic [2:0] AD_DVS = 3'd4;

  logic [7:0]  opa_q;
  logic [15:0] dvd_q;
  logic [15:0] quo_q, pr_q;
  logic        is_div_q;
  logic [4:0]  left_q;
  logic [15:0] mcand_q, prod_q;
  logic [7:0]  mplier_q;
  logic [15:0] dq_q;
  logic [7:0]  rem_q, dvs_q;

  wire go_mul = wr_en && (wr_addr == AD_OPB);
  wire go_div = wr_en && (wr_addr == AD_DVS);
  wire last   = (left_q == 5'd1);

  wire [8:0]  trial = {rem_q, dq_q[15]};
  wire        ge    = (trial >= {1'b0, dvs_q});
  wire [8:0]  diff  = trial - {1'b0, dvs_q};
  wire [7:0]  nrem  = ge ? diff[7:0] : trial[7:0];
  wire [15:0] nprod = prod_q + (mplier_q[0] ? mcand_q : 16'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      opa_q    <= '0;
      dvd_q    <= '0;
      quo_q    <= '0;
      pr_q     <= '0;
      is_div_q <= 1'b0;
      left_q   <= '0;
      mcand_q  <= '0;
      prod_q   <= '0;
      mplier_q <= '0;
      dq_q     <= '0;
      rem_q    <= '0;
      dvs_q    <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (wr_en) begin
        case (wr_addr)
          AD_OPA:  opa_q        <= wr_data;
          AD_DLO:  dvd_q[7:0]   <= wr_data;
          AD_DHI:  dvd_q[15:8]  <= wr_data;
          default: ;
        endcase
      end
      if (go_mul) begin
        is_div_q <= 1'b0;
        left_q   <= MUL_STEPS;
        busy     <= 1'b1;
        mcand_q  <= {8'd0, opa_q};
        mplier_q <= wr_data;
        prod_q   <= '0;
      end else if (go_div) begin
        if (wr_data == 8'd0) begin
          busy   <= 1'b0;
          left_q <= '0;
          done   <= 1'b1;
          quo_q  <= 16'hFFFF;
          pr_q   <= dvd_q;
        end else begin
          is_div_q <= 1'b1;
          left_q   <= DIV_STEPS;
          busy     <= 1'b1;
          dq_q     <= dvd_q;
          rem_q    <= '0;
          dvs_q    <= wr_data;
        end
      end else if (busy) begin
        left_q <= left_q - 5'd1;
        if (is_div_q) begin
          dq_q  <= {dq_q[14:0], ge};
          rem_q <= nrem;
        end else begin
          prod_q   <= nprod;
          mcand_q  <= {mcand_q[14:0], 1'b0};
          mplier_q <= {1'b0, mplier_q[7:1]};
        end
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (is_div_q) begin
            quo_q <= {dq_q[14:0], ge};
            pr_q  <= {8'd0, nrem};
          end else begin
            pr_q <= nprod;
          end
        end
      end
    end
  end

  always_comb begin
    case (rd_addr)
      2'd0:    rd_data = quo_q[7:0];
      2'd1:    rd_data = quo_q[15:8];
      2'd2:    rd_data = pr_q[7:0];
      default: rd_data = pr_q[15:8];
    endcase
  end
endmodule

// File: rtl/arith_helper_chk.sv
module arith_helper_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic        busy,
  input logic        done,
  input logic [15:0] quo,
  input logic [15:0] pr
);
  logic [7:0]  m_a;
  logic [15:0] m_dvd;
  logic [15:0] exp_q, exp_pr;
  logic        exp_vld, exp_div;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_a     <= '0;
      m_dvd   <= '0;
      exp_q   <= '0;
      exp_pr  <= '0;
      exp_vld <= 1'b0;
      exp_div <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        3'd0: m_a         <= wr_data;
        3'd2: m_dvd[7:0]  <= wr_data;
        3'd3: m_dvd[15:8] <= wr_data;
        3'd1: begin
          exp_vld <= 1'b1;
          exp_div <= 1'b0;
          exp_q   <= quo;
          exp_pr  <= {8'd0, m_a} * {8'd0, wr_data};
        end
        3'd4: begin
          exp_vld <= 1'b1;
          exp_div <= 1'b1;
          if (wr_data == 8'd0) begin
            exp_q  <= 16'hFFFF;
            exp_pr <= m_dvd;
          end else begin
            exp_q  <= m_dvd / {8'd0, wr_data};
            exp_pr <= m_dvd % {8'd0, wr_data};
          end
        end
        default: ;
      endcase
    end
  end

  // R1
  mul_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd1) |=> (busy && !done));

  // R1
  mul_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exp_vld && !exp_div) |-> (pr == exp_pr && quo == exp_q));

  // R2
  div_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exp_vld && exp_div) |-> (pr == exp_pr && quo == exp_q));

  // R3
  idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && (wr_addr == 3'd0 || wr_addr == 3'd2 || wr_addr == 3'd3 || wr_addr > 3'd4))
      |=> (!busy && !done));

  // R5
  div_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 3'd4 && wr_data == 8'd0) |=> (done && !busy && quo == 16'hFFFF));

  // R6
  done_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quo) && $stable(pr)));
endmodule

bind arith_helper arith_helper_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .busy    (busy),
  .done    (done),
  .quo     (quo_q),
  .pr      (pr_q)
);

// File: tb/arith_helper_tb.sv
module arith_helper_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {is_div, x, y, exp_q, exp_pr}; for multiply x[7:0] is A and exp_q is unused
  localparam logic [56:0] VEC [NVEC] = '{
    {1'b0, 16'h0000, 8'h37, 16'h0000, 16'h0000},
    {1'b0, 16'h00FF, 8'hFF, 16'h0000, 16'hFE01},
    {1'b0, 16'h0012, 8'h10, 16'h0000, 16'h0120},
    {1'b0, 16'h0001, 8'hAB, 16'h0000, 16'h00AB},
    {1'b1, 16'hFFFF, 8'h01, 16'hFFFF, 16'h0000},
    {1'b1, 16'h1234, 8'h10, 16'h0123, 16'h0004},
    {1'b0, 16'h0080, 8'h02, 16'h0000, 16'h0100},
    {1'b1, 16'h03E8, 8'h07, 16'h008E, 16'h0006},
    {1'b1, 16'h0005, 8'h09, 16'h0000, 16'h0005},
    {1'b1, 16'hFFFF, 8'hFF, 16'h0101, 16'h0000},
    {1'b1, 16'h0100, 8'h00, 16'hFFFF, 16'h0100}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       busy, done;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] last_q = '0;

  arith_helper u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd16(input logic [1:0] lo, output logic [15:0] v);
    rd_addr = lo; #1; v[7:0] = rd_data;
    rd_addr = lo + 2'd1; #1; v[15:8] = rd_data;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %h expected %h", 16'd0, 16'd1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] q, p;
    int lat;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state and read map
    chk(!busy && !done, "R10 idle after reset", {14'd0, busy, done}, 16'd0);
    rd16(2'd0, q); rd16(2'd2, p);
    chk(q == 16'd0, "R10 quotient reset", q, 16'd0);
    chk(p == 16'd0, "R10 shared reset", p, 16'd0);

    for (int i = 0; i < NVEC; i++) begin
      logic        isd;
      logic [15:0] x, eq, ep;
      logic [7:0]  y;
      int          exp_lat;
      {isd, x, y, eq, ep} = VEC[i];
      if (!isd) begin
        wr(3'd0, x[7:0]);
        wr(3'd1, y);
        eq = last_q;
        exp_lat = 8;
      end else begin
        wr(3'd2, x[7:0]);
        wr(3'd3, x[15:8]);
        wr(3'd4, y);
        exp_lat = (y == 8'd0) ? 0 : 16;
      end
      wait_done(lat);
      chk(lat == exp_lat, isd ? (y == 8'd0 ? "R5 zero divisor latency" : "R6 divide latency") : "R6 multiply latency",
          lat[15:0], exp_lat[15:0]);
      rd16(2'd0, q); rd16(2'd2, p);
      chk(q == eq, isd ? (y == 8'd0 ? "R5 zero divisor quotient" : "R2 quotient") : "R1 quotient kept", q, eq);
      chk(p == ep, isd ? (y == 8'd0 ? "R5 zero divisor remainder" : "R2 remainder") : "R1 product", p, ep);
      last_q = eq;
      @(negedge clk);
      chk(!done && !busy, "R6 done lasts one cycle", {14'd0, busy, done}, 16'd0);
    end

    // R3 dividend and A writes start nothing
    wr(3'd2, 8'h55);
    chk(!busy && !done, "R3 dividend low write", {14'd0, busy, done}, 16'd0);
    wr(3'd3, 8'h66);
    chk(!busy && !done, "R3 dividend high write", {14'd0, busy, done}, 16'd0);
    wr(3'd0, 8'h09);
    chk(!busy && !done, "R3 multiplicand write", {14'd0, busy, done}, 16'd0);

    // R4 unused addresses ignored
    wr(3'd5, 8'hAA); wr(3'd6, 8'h00); wr(3'd7, 8'hFF);
    chk(!busy && !done, "R4 unused address", {14'd0, busy, done}, 16'd0);
    rd16(2'd0, q); rd16(2'd2, p);
    chk(q == 16'hFFFF, "R4 quotient untouched", q, 16'hFFFF);
    chk(p == 16'h0100, "R4 shared untouched", p, 16'h0100);

    // R8 restart while busy, R7 hold during busy
    wr(3'd0, 8'h03);
    wr(3'd1, 8'h05);
    @(negedge clk);
    chk(busy && !done, "R8 running before restart", {14'd0, busy, done}, 16'd2);
    rd16(2'd2, p);
    chk(p == 16'h0100, "R7 shared held while busy", p, 16'h0100);
    wr(3'd1, 8'h07);
    wait_done(lat);
    chk(lat == 8, "R8 latency from restart", lat[15:0], 16'd8);
    rd16(2'd2, p);
    chk(p == 16'h0015, "R8 restarted product", p, 16'h0015);

    // R9 operand change during busy
    wr(3'd0, 8'h10);
    wr(3'd1, 8'h10);
    wr(3'd0, 8'h01);
    rd16(2'd2, p);
    chk(p == 16'h0015, "R7 shared held mid multiply", p, 16'h0015);
    wait_done(lat);
    rd16(2'd2, p);
    chk(p == 16'h0100, "R9 captured multiplicand", p, 16'h0100);

    wr(3'd2, 8'h64); wr(3'd3, 8'h00);
    wr(3'd4, 8'h0A);
    wr(3'd2, 8'hFF);
    wait_done(lat);
    rd16(2'd0, q); rd16(2'd2, p);
    chk(q == 16'h000A, "R9 captured dividend quotient", q, 16'h000A);
    chk(p == 16'h0000, "R9 captured dividend remainder", p, 16'h0000);

    // R8 restart from multiply into divide
    wr(3'd1, 8'h02);
    wr(3'd4, 8'h10);
    wait_done(lat);
    chk(lat == 16, "R8 divide restart latency", lat[15:0], 16'd16);
    rd16(2'd0, q); rd16(2'd2, p);
    chk(q == 16'h000F, "R8 divide restart quotient", q, 16'h000F);
    chk(p == 16'h000F, "R8 divide restart remainder", p, 16'h000F);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule